// File: doc/BRIEF.md
# Byte-Laned Dual-Port RAM with Contention Arbitration

This block is a synchronous true dual-port memory. It has two symmetric ports, left and right, on one clock. Each port has a select, a write strobe, an output enable, an upper-lane enable, a lower-lane enable, an address, write data and registered read data. Each byte lane of the read data carries its own valid flag. A lane whose flag is low reads as zero, and this stands in for an undriven pad. With `ADDR_W` set to 13 the block holds 8K words of 16 bits. The default is smaller, to keep elaboration light.

A strap input picks the role of the block. As a master, it watches for both ports being active at one address. It grants the address to the port that got there first and drives an active-low busy output to the other port. The losing port's write is dropped in that cycle, but its read still returns array data. As a slave, the block does no arbitration of its own. Each port instead takes an active-low busy input, normally wired from a master's busy output, and that input suppresses the port's writes. This lets two blocks be cascaded side by side into a wider word with no glue logic.

Reads have one cycle of latency and return the contents from before the edge. A write on one port and a read of the same word on the other port in the same cycle therefore returns the old data; the new data appears one cycle later.

Top module: `dpram_arb`

## Requirements
- R1: A write changes only the byte lanes whose enable is high. Bits [15:8] are the upper lane and bits [7:0] the lower lane.
- R2: A read issued in cycle n sets, after that clock edge, the valid flag of each enabled lane and returns the stored byte on it. A lane that was not enabled has its flag low and reads as zero.
- R3: A port whose select is low, or whose two lane enables are both low, neither writes nor raises any valid flag.
- R4: A read with output enable low raises no valid flag, and the read data is zero.
- R5: The array is written only when a port has both select and write strobe high.
- R6: As a master, when both ports are active at one address, the port that was already active at that address in the previous cycle keeps it. The other port sees its busy output low in the same cycle, and the grant holds while the match lasts.
- R7: As a master, when both ports first become active at one address in the same cycle, the left port wins and the right busy output goes low.
- R8: A busy output returns high as soon as the addresses differ or either port becomes inactive. Busy outputs are never low outside a master-mode address match.
- R9: The port that loses arbitration has its write dropped in that cycle, while its read still returns the stored word.
- R10: As a slave, both busy outputs stay high. A low busy input blocks that port's writes, and a high one allows them.
- R11: A read of a word being written by the other port in the same cycle returns the old contents; the new contents are returned one cycle later.
- R12: After reset every valid flag is low and both busy outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| master | input | 1 | 1: arbitrate and drive busy; 0: obey busy inputs |
| l_sel | input | 1 | Left port select |
| l_we | input | 1 | Left write strobe (1 write, 0 read) |
| l_oe | input | 1 | Left output enable |
| l_ub | input | 1 | Left upper-lane enable |
| l_lb | input | 1 | Left lower-lane enable |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 2*LANE_W | Left write data |
| l_rdata | output | 2*LANE_W | Left read data, zero on invalid lanes |
| l_vld_hi | output | 1 | Left upper-lane read data valid |
| l_vld_lo | output | 1 | Left lower-lane read data valid |
| l_busy_n_i | input | 1 | Left write inhibit in slave mode, active low |
| l_busy_n_o | output | 1 | Left lost arbitration, active low |
| r_sel | input | 1 | Right port select |
| r_we | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_ub | input | 1 | Right upper-lane enable |
| r_lb | input | 1 | Right lower-lane enable |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 2*LANE_W | Right write data |
| r_rdata | output | 2*LANE_W | Right read data, zero on invalid lanes |
| r_vld_hi | output | 1 | Right upper-lane read data valid |
| r_vld_lo | output | 1 | Right lower-lane read data valid |
| r_busy_n_i | input | 1 | Right write inhibit in slave mode, active low |
| r_busy_n_o | output | 1 | Right lost arbitration, active low |

## Verification
The properties assume that every input is a known value once reset is released. They also assume that the master strap changes only while both ports are idle, because the grant memory is meaningful only within one mode. The bench drives all inputs on the falling clock edge and flips the strap only between scenarios with both ports deselected. In slave mode it drives the busy inputs directly in place of a second device, so the block's own outputs can be checked to stay high.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    // Which port currently holds a contended address
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

endpackage

// File: rtl/dpram_lane_mem.sv
// One byte lane of storage with two read/write ports. Reads return the
// contents before the edge. On a same-cycle double write, port A lands last.
module dpram_lane_mem #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_wen,
    input  logic [LANE_W-1:0] a_wd,
    output logic [LANE_W-1:0] a_rd,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_wen,
    input  logic [LANE_W-1:0] b_wd,
    output logic [LANE_W-1:0] b_rd
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        a_rd <= store[a_addr];
        b_rd <= store[b_addr];
        if (b_wen) store[b_addr] <= b_wd;
        if (a_wen) store[a_addr] <= a_wd;
    end
endmodule

// File: rtl/dpram_arbiter.sv
// Same-address contention resolver used in master mode.
module dpram_arbiter
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master,
    input  logic              l_act,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_act,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_lose,
    output logic              r_lose
);
    typedef struct packed {
        owner_e            owner;
        logic              l_act;
        logic              r_act;
        logic [ADDR_W-1:0] l_addr;
        logic [ADDR_W-1:0] r_addr;
    } arb_state_t;

    arb_state_t st_d, st_q;
    logic       match, l_early, r_early;
    owner_e     winner;

    always_comb begin
        match   = master && l_act && r_act && (l_addr == r_addr);
        l_early = st_q.l_act && (st_q.l_addr == l_addr);
        r_early = st_q.r_act && (st_q.r_addr == r_addr);

        if (!match)                     winner = OWN_NONE;
        else if (st_q.owner != OWN_NONE) winner = st_q.owner;
        else if (r_early && !l_early)    winner = OWN_RIGHT;
        else                             winner = OWN_LEFT;

        l_lose = (winner == OWN_RIGHT);
        r_lose = (winner == OWN_LEFT);

        st_d        = st_q;
        st_d.owner  = winner;
        st_d.l_act  = l_act;
        st_d.r_act  = r_act;
        st_d.l_addr = l_addr;
        st_d.r_addr = r_addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{owner: OWN_NONE, l_act: 1'b0, r_act: 1'b0,
                      l_addr: '0, r_addr: '0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  master,
    input  logic                  l_sel,
    input  logic                  l_we,
    input  logic                  l_oe,
    input  logic                  l_ub,
    input  logic                  l_lb,
    input  logic [ADDR_W-1:0]     l_addr,
    input  logic [2*LANE_W-1:0]   l_wdata,
    output logic [2*LANE_W-1:0]   l_rdata,
    output logic                  l_vld_hi,
    output logic                  l_vld_lo,
    input  logic                  l_busy_n_i,
    output logic                  l_busy_n_o,
    input  logic                  r_sel,
    input  logic                  r_we,
    input  logic                  r_oe,
    input  logic                  r_ub,
    input  logic                  r_lb,
    input  logic [ADDR_W-1:0]     r_addr,
    input  logic [2*LANE_W-1:0]   r_wdata,
    output logic [2*LANE_W-1:0]   r_rdata,
    output logic                  r_vld_hi,
    output logic                  r_vld_lo,
    input  logic                  r_busy_n_i,
    output logic                  r_busy_n_o
);
    localparam int LANES = 2;   // index 0 = lower, 1 = upper

    typedef struct packed {
        logic [LANES-1:0] l_vld;
        logic [LANES-1:0] r_vld;
    } out_state_t;

    out_state_t       st_d, st_q;
    logic             l_act, r_act, l_lose, r_lose, l_blk, r_blk;
    logic [LANES-1:0] l_en, r_en, l_wen, r_wen;
    logic [LANE_W-1:0] l_lane_rd [LANES];
    logic [LANE_W-1:0] r_lane_rd [LANES];

    dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .master (master),
        .l_act  (l_act),
        .l_addr (l_addr),
        .r_act  (r_act),
        .r_addr (r_addr),
        .l_lose (l_lose),
        .r_lose (r_lose)
    );

    always_comb begin
        l_en  = {l_ub, l_lb};
        r_en  = {r_ub, r_lb};
        l_act = l_sel && (|l_en);
        r_act = r_sel && (|r_en);
        l_blk = master ? l_lose : !l_busy_n_i;
        r_blk = master ? r_lose : !r_busy_n_i;
        l_wen = (l_sel && l_we && !l_blk) ? l_en : '0;
        r_wen = (r_sel && r_we && !r_blk) ? r_en : '0;

        st_d       = st_q;
        st_d.l_vld = (l_sel && !l_we && l_oe) ? l_en : '0;
        st_d.r_vld = (r_sel && !r_we && r_oe) ? r_en : '0;

        l_busy_n_o = !(master && l_lose);
        r_busy_n_o = !(master && r_lose);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dpram_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
            .clk    (clk),
            .a_addr (l_addr),
            .a_wen  (l_wen[g]),
            .a_wd   (l_wdata[g*LANE_W +: LANE_W]),
            .a_rd   (l_lane_rd[g]),
            .b_addr (r_addr),
            .b_wen  (r_wen[g]),
            .b_wd   (r_wdata[g*LANE_W +: LANE_W]),
            .b_rd   (r_lane_rd[g])
        );
        assign l_rdata[g*LANE_W +: LANE_W] = st_q.l_vld[g] ? l_lane_rd[g] : '0;
        assign r_rdata[g*LANE_W +: LANE_W] = st_q.r_vld[g] ? r_lane_rd[g] : '0;
    end

    assign l_vld_hi = st_q.l_vld[1];
    assign l_vld_lo = st_q.l_vld[0];
    assign r_vld_hi = st_q.r_vld[1];
    assign r_vld_lo = st_q.r_vld[0];
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master,
    input logic              l_sel,
    input logic              l_oe,
    input logic              l_ub,
    input logic              l_lb,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_vld_hi,
    input logic              l_vld_lo,
    input logic              l_busy_n_o,
    input logic              r_sel,
    input logic              r_oe,
    input logic              r_ub,
    input logic              r_lb,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_vld_hi,
    input logic              r_vld_lo,
    input logic              r_busy_n_o
);
    AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!l_busy_n_o, !r_busy_n_o}) <= 1); // R6

    AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n_o || !r_busy_n_o) |-> (master && l_sel && r_sel &&
        (l_ub || l_lb) && (r_ub || r_lb) && l_addr == r_addr)); // R8

    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !master |-> (l_busy_n_o && r_busy_n_o)); // R10

    AST_L_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_oe || !l_sel) |=> (!l_vld_hi && !l_vld_lo)); // R4

    AST_R_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_oe || !r_sel) |=> (!r_vld_hi && !r_vld_lo)); // R4
endmodule

bind dpram_arb dpram_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .master(master),
    .l_sel(l_sel), .l_oe(l_oe), .l_ub(l_ub), .l_lb(l_lb), .l_addr(l_addr),
    .l_vld_hi(l_vld_hi), .l_vld_lo(l_vld_lo), .l_busy_n_o(l_busy_n_o),
    .r_sel(r_sel), .r_oe(r_oe), .r_ub(r_ub), .r_lb(r_lb), .r_addr(r_addr),
    .r_vld_hi(r_vld_hi), .r_vld_lo(r_vld_lo), .r_busy_n_o(r_busy_n_o)
);

// File: tb/sim_dpram_arb.sv
`timescale 1ns/1ps
module sim_dpram_arb;
    localparam int AW = 10;
    localparam int LW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master = 1'b1;
    logic l_sel = 0, l_we = 0, l_oe = 0, l_ub = 0, l_lb = 0;
    logic r_sel = 0, r_we = 0, r_oe = 0, r_ub = 0, r_lb = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [15:0] l_wdata = '0, r_wdata = '0, l_rdata, r_rdata;
    logic l_vld_hi, l_vld_lo, r_vld_hi, r_vld_lo;
    logic l_busy_n_i = 1'b1, r_busy_n_i = 1'b1, l_busy_n_o, r_busy_n_o;

    int nchk = 0, nerr = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dpram_arb #(.ADDR_W(AW), .LANE_W(LW)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic setl(input logic s, w, o, u, lo, input logic [AW-1:0] a, input logic [15:0] d);
        l_sel = s; l_we = w; l_oe = o; l_ub = u; l_lb = lo; l_addr = a; l_wdata = d;
    endtask

    task automatic setr(input logic s, w, o, u, lo, input logic [AW-1:0] a, input logic [15:0] d);
        r_sel = s; r_we = w; r_oe = o; r_ub = u; r_lb = lo; r_addr = a; r_wdata = d;
    endtask

    task automatic idle();
        setl(0, 0, 0, 0, 0, '0, '0);
        setr(0, 0, 0, 0, 0, '0, '0);
    endtask

    // one-cycle left write, then idle
    task automatic lwrite(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk); setl(1, 1, 1, 1, 1, a, d);
        @(negedge clk); idle();
    endtask

    // full-word left read; checks data on the following falling edge
    task automatic lread(input string req, input logic [AW-1:0] a, input logic [15:0] exp);
        @(negedge clk); setl(1, 0, 1, 1, 1, a, '0);
        @(negedge clk); chk(req, l_rdata, exp); chk(req, {l_vld_hi, l_vld_lo}, 2'b11);
        idle();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R12 vld", {l_vld_hi, l_vld_lo, r_vld_hi, r_vld_lo}, 4'b0000);
        chk("R12 busy", {l_busy_n_o, r_busy_n_o}, 2'b11);
    endtask

    task automatic t_lanes();
        @(negedge clk); setl(1, 1, 1, 1, 1, 5, 16'hA1B2);
        @(negedge clk); setl(1, 1, 1, 1, 0, 5, 16'hCC00);
        @(negedge clk); idle();
        lread("R1 upper-only write", 5, 16'hCCB2);
        @(negedge clk); setl(1, 0, 1, 0, 1, 5, '0);
        @(negedge clk);
        chk("R2 lower-only data", l_rdata, 16'h00B2);
        chk("R2 lower-only flags", {l_vld_hi, l_vld_lo}, 2'b01);
        idle();
    endtask

    task automatic t_deselect();
        @(negedge clk); setl(1, 1, 1, 0, 0, 5, 16'hFFFF);
        @(negedge clk); setl(0, 1, 1, 1, 1, 5, 16'hFFFF);
        @(negedge clk); setl(0, 0, 1, 1, 1, 5, '0);
        @(negedge clk);
        chk("R3 sel low read", {l_vld_hi, l_vld_lo}, 2'b00);
        setl(1, 0, 1, 0, 0, 5, '0);
        @(negedge clk);
        chk("R3 no lanes read", {l_vld_hi, l_vld_lo}, 2'b00);
        idle();
        lread("R5 R3 no stray write", 5, 16'hCCB2);
    endtask

    task automatic t_oe();
        @(negedge clk); setl(1, 0, 0, 1, 1, 5, '0);
        @(negedge clk);
        chk("R4 oe low flags", {l_vld_hi, l_vld_lo}, 2'b00);
        chk("R4 oe low data", l_rdata, 16'h0000);
        idle();
    endtask

    task automatic t_rdw();
        lwrite(7, 16'h1111);
        @(negedge clk); setl(1, 1, 1, 1, 1, 7, 16'h2222); setr(1, 0, 1, 1, 1, 7, '0);
        #1;
        chk("R7 right busy", {l_busy_n_o, r_busy_n_o}, 2'b10);
        @(negedge clk);
        chk("R11 old data", r_rdata, 16'h1111);
        chk("R9 loser read valid", {r_vld_hi, r_vld_lo}, 2'b11);
        setl(0, 0, 0, 0, 0, '0, '0);
        @(negedge clk);
        chk("R11 new data", r_rdata, 16'h2222);
        idle();
    endtask

    task automatic t_first();
        lwrite(9, 16'h0909);
        @(negedge clk); setr(1, 0, 1, 1, 1, 9, '0);
        @(negedge clk); setl(1, 1, 1, 1, 1, 9, 16'h5555);
        #1;
        chk("R6 later port busy", {l_busy_n_o, r_busy_n_o}, 2'b01);
        @(negedge clk); setl(1, 0, 1, 1, 1, 9, '0);
        #1;
        chk("R6 grant held", {l_busy_n_o, r_busy_n_o}, 2'b01);
        @(negedge clk);
        chk("R9 loser write dropped", l_rdata, 16'h0909);
        setr(0, 0, 0, 0, 0, '0, '0);
        #1;
        chk("R8 winner deselect", {l_busy_n_o, r_busy_n_o}, 2'b11);
        @(negedge clk); setr(1, 0, 1, 1, 1, 9, '0);
        #1;
        chk("R6 left earlier", {l_busy_n_o, r_busy_n_o}, 2'b10);
        @(negedge clk); setr(1, 0, 1, 1, 1, 10, '0);
        #1;
        chk("R8 address change", {l_busy_n_o, r_busy_n_o}, 2'b11);
        @(negedge clk); idle();
    endtask

    task automatic t_simul();
        @(negedge clk);
        setl(1, 1, 1, 1, 1, 11, 16'hAAAA); setr(1, 1, 1, 1, 1, 11, 16'hBBBB);
        #1;
        chk("R7 tie to left", {l_busy_n_o, r_busy_n_o}, 2'b10);
        @(negedge clk); idle();
        lread("R9 R7 left data kept", 11, 16'hAAAA);
    endtask

    task automatic t_slave();
        @(negedge clk); master = 1'b0;
        @(negedge clk); setr(1, 1, 1, 1, 1, 13, 16'h3131);
        @(negedge clk); idle();
        @(negedge clk); l_busy_n_i = 1'b0;
        setl(1, 1, 1, 1, 1, 13, 16'h1313); setr(1, 0, 1, 1, 1, 13, '0);
        #1;
        chk("R10 slave outputs high", {l_busy_n_o, r_busy_n_o}, 2'b11);
        @(negedge clk); l_busy_n_i = 1'b1; idle();
        lread("R10 inhibited write", 13, 16'h3131);
        lwrite(13, 16'h1313);
        lread("R10 allowed write", 13, 16'h1313);
        @(negedge clk); master = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lanes();
        t_deselect();
        t_oe();
        t_rdw();
        t_first();
        t_simul();
        t_slave();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nerr++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule